// File: doc/BRIEF.md
# SDRAM Auto-Refresh Scheduler

This block lives inside a memory controller and keeps one rank of synchronous DRAM refreshed. A free-running interval timer decides when a refresh is owed. The period is either the normal one or, when the hot-range input is high, half of it. Each time the timer expires, a backlog counter goes up by one. While the backlog is non-zero, the block raises a request towards the command arbiter.

When the arbiter grants the request, the block samples the per-bank open-row flags. If any bank is open, it issues a single precharge-all command and waits out the precharge time. It then issues the auto-refresh command and keeps the rank blocked for the full refresh cycle time. All devices of the rank receive the same command, so the rank is refreshed together.

The arbiter may withhold the grant to postpone refreshes. Once the backlog reaches its limit, the block raises an urgent flag and stalls normal read and write traffic until a refresh goes out. Timing values are parameters in clock cycles. At 50 MHz the defaults give 390 cycles (7.8 us) normally and 195 cycles (3.9 us) in the hot range.

Top module: `sdram_refresh_sched`

## Requirements
- R1: With the grant held high, no open bank and `hot_i` low, successive `ref_o` pulses are exactly REFI_CYC clock cycles apart (390 by default, 7.8 us at 50 MHz).
- R2: With `hot_i` high and settled, successive `ref_o` pulses are exactly REFI_CYC/2 cycles apart (195 by default, 3.9 us at 50 MHz).
- R3: A change of `hot_i` is taken at the next timer reload only. The interval already running keeps its old length, and the one after it uses the new length.
- R4: If any bit of `bank_open_i` is 1 in the grant cycle, `pre_all_o` pulses for one cycle in the cycle after the grant, and `ref_o` follows exactly T_RP cycles after that pulse. Changes to `bank_open_i` after the grant do not alter this sequence.
- R5: If all bits of `bank_open_i` are 0 in the grant cycle, `ref_o` pulses in the cycle after the grant and `pre_all_o` stays low.
- R6: `stall_o` is high from the first command of a granted sequence up to and including cycle T_RFC-1 after the `ref_o` pulse. It is low in cycle T_RFC after the pulse unless the urgent condition holds.
- R7: `req_o` is high while a refresh is owed and the sequence has not been granted. While merely waiting for the grant below the urgent limit, `stall_o` stays low. A grant while nothing is owed issues no command.
- R8: Up to MAX_PEND (8) refreshes can be owed. `urgent_o` is high exactly when the backlog equals MAX_PEND, and `urgent_o` forces `stall_o` high. The count saturates at MAX_PEND. After a grant, owed refreshes go out back to back, T_RFC+2 cycles apart, and `urgent_o` drops in the cycle after the first of them.
- R9: Reset clears the timer and the backlog and drives `req_o`, `urgent_o`, `pre_all_o`, `ref_o` and `stall_o` low. The first interval after reset uses the normal period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hot_i | input | 1 | Extended temperature range; halves the refresh period |
| gnt_i | input | 1 | Grant from the command arbiter |
| bank_open_i | input | NUM_BANKS | One flag per bank, 1 when a row is open |
| req_o | output | 1 | Refresh request to the arbiter |
| urgent_o | output | 1 | Backlog is at its limit; refresh must win |
| pre_all_o | output | 1 | One-cycle precharge-all command |
| ref_o | output | 1 | One-cycle auto-refresh command |
| stall_o | output | 1 | Block new reads and writes to the rank |

## Verification
The refresh period is measured between successive commands, with the temperature input held low, held high, and toggled just after a command. The toggle separates a design that reloads the timer at once from one that waits for the next reload. The granted sequence is driven once with open banks, whose flags are then cleared after the grant, and once with all banks closed. This tells the precharge path and its T_RP spacing apart from the direct path, and shows whether late flag changes leak in. A long withheld grant fills the backlog, which checks the urgent threshold, saturation, the back-to-back drain spacing and the drop of the urgent flag. A reset in the middle of the refresh hold confirms that every output clears.

// File: rtl/ref_sched_pkg.sv
package ref_sched_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_GNT,
    ST_PRE_ALL,
    ST_WAIT_RP,
    ST_AUTO_REF,
    ST_WAIT_RFC
  } rs_state_e;

  // Refresh period in cycles for the selected temperature range.
  function automatic int unsigned pick_interval(input logic hot, input int unsigned base);
    return hot ? (base / 2) : base;
  endfunction

  // Wait-state counter preload so that the next command lands n cycles
  // after the previous one (one command cycle plus n-1 wait cycles).
  function automatic int unsigned wait_preload(input int unsigned n);
    return n - 2;
  endfunction

endpackage

// File: rtl/ref_interval_timer.sv
module ref_interval_timer
  import ref_sched_pkg::*;
#(
  parameter int unsigned BASE_CYC = 390
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hot_i,
  output logic tick_o
);

  localparam int unsigned CW = $clog2(BASE_CYC);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim_q;

  assign tick_o = (cnt_q == lim_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lim_q <= CW'(pick_interval(1'b0, BASE_CYC) - 1);
    end else if (tick_o) begin
      cnt_q <= '0;
      lim_q <= CW'(pick_interval(hot_i, BASE_CYC) - 1);
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_TICK_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o); // R1

endmodule

// File: rtl/ref_pend_ctr.sv
module ref_pend_ctr #(
  parameter int unsigned MAX_PEND = 8
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             inc_i,
  input  logic                             dec_i,
  output logic [$clog2(MAX_PEND+1)-1:0]    cnt_o,
  output logic                             urgent_o
);

  localparam int unsigned PW = $clog2(MAX_PEND + 1);
  localparam logic [PW-1:0] LIMIT = PW'(MAX_PEND);

  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      unique case ({inc_i, dec_i})
        2'b10:   if (cnt_q < LIMIT) cnt_q <= cnt_q + 1'b1;
        2'b01:   if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign cnt_o    = cnt_q;
  assign urgent_o = (cnt_q >= LIMIT);

  AST_PEND_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LIMIT); // R8

endmodule

// File: rtl/ref_seq_fsm.sv
module ref_seq_fsm
  import ref_sched_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 8,
  parameter int unsigned T_RP      = 3,
  parameter int unsigned T_RFC     = 18
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 owed_i,
  input  logic                 urgent_i,
  input  logic                 gnt_i,
  input  logic [NUM_BANKS-1:0] bank_open_i,
  output logic                 req_o,
  output logic                 pre_all_o,
  output logic                 ref_o,
  output logic                 stall_o
);

  localparam int unsigned WMAX = (T_RP > T_RFC) ? T_RP : T_RFC;
  localparam int unsigned WW   = (WMAX > 2) ? $clog2(WMAX) : 1;

  rs_state_e     st_q, st_d;
  logic [WW-1:0] wcnt_q, wcnt_d;
  logic          busy;
  logic          any_open;

  assign any_open = |bank_open_i;

  always_comb begin
    st_d   = st_q;
    wcnt_d = wcnt_q;
    unique case (st_q)
      ST_IDLE:     if (owed_i) st_d = ST_WAIT_GNT;
      ST_WAIT_GNT: if (gnt_i)  st_d = any_open ? ST_PRE_ALL : ST_AUTO_REF;
      ST_PRE_ALL: begin
        wcnt_d = WW'(wait_preload(T_RP));
        st_d   = ST_WAIT_RP;
      end
      ST_WAIT_RP: begin
        if (wcnt_q == '0) st_d = ST_AUTO_REF;
        else              wcnt_d = wcnt_q - 1'b1;
      end
      ST_AUTO_REF: begin
        wcnt_d = WW'(wait_preload(T_RFC));
        st_d   = ST_WAIT_RFC;
      end
      ST_WAIT_RFC: begin
        if (wcnt_q == '0) st_d = ST_IDLE;
        else              wcnt_d = wcnt_q - 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      wcnt_q <= '0;
    end else begin
      st_q   <= st_d;
      wcnt_q <= wcnt_d;
    end
  end

  assign busy      = (st_q == ST_PRE_ALL) || (st_q == ST_WAIT_RP) ||
                     (st_q == ST_AUTO_REF) || (st_q == ST_WAIT_RFC);
  assign req_o     = (st_q == ST_WAIT_GNT);
  assign pre_all_o = (st_q == ST_PRE_ALL);
  assign ref_o     = (st_q == ST_AUTO_REF);
  assign stall_o   = busy || urgent_i;

  AST_ONE_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pre_all_o && ref_o)); // R4
  AST_PRE_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_all_o |=> (!ref_o && stall_o)); // R4
  AST_RFC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_o |=> (stall_o && !ref_o && !pre_all_o)); // R6
  AST_URGENT_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    urgent_i |-> stall_o); // R8
  AST_CMD_NEEDS_OWED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !gnt_i) |=> (!pre_all_o && !ref_o)); // R7

endmodule

// File: rtl/sdram_refresh_sched.sv
module sdram_refresh_sched #(
  parameter int unsigned NUM_BANKS = 8,
  parameter int unsigned REFI_CYC  = 390,
  parameter int unsigned T_RP      = 3,
  parameter int unsigned T_RFC     = 18,
  parameter int unsigned MAX_PEND  = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 hot_i,
  input  logic                 gnt_i,
  input  logic [NUM_BANKS-1:0] bank_open_i,
  output logic                 req_o,
  output logic                 urgent_o,
  output logic                 pre_all_o,
  output logic                 ref_o,
  output logic                 stall_o
);

  localparam int unsigned PW = $clog2(MAX_PEND + 1);

  logic          tick;
  logic [PW-1:0] pend_cnt;
  logic          urgent;
  logic          ref_issue;

  ref_interval_timer #(.BASE_CYC(REFI_CYC)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hot_i  (hot_i),
    .tick_o (tick)
  );

  ref_pend_ctr #(.MAX_PEND(MAX_PEND)) u_pend (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .inc_i    (tick),
    .dec_i    (ref_issue),
    .cnt_o    (pend_cnt),
    .urgent_o (urgent)
  );

  ref_seq_fsm #(.NUM_BANKS(NUM_BANKS), .T_RP(T_RP), .T_RFC(T_RFC)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .owed_i      (pend_cnt != '0),
    .urgent_i    (urgent),
    .gnt_i       (gnt_i),
    .bank_open_i (bank_open_i),
    .req_o       (req_o),
    .pre_all_o   (pre_all_o),
    .ref_o       (ref_issue),
    .stall_o     (stall_o)
  );

  assign ref_o    = ref_issue;
  assign urgent_o = urgent;

  AST_DEC_ON_REF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_issue && !tick) |=> ((pend_cnt + 1'b1) == $past(pend_cnt))); // R8
  AST_REF_NEEDS_OWED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_issue |-> (pend_cnt != '0)); // R7

endmodule

// File: tb/test_sdram_refresh_sched.sv
module test_sdram_refresh_sched;

  localparam int NB    = 8;
  localparam int REFI  = 390;   // 7.8 us at 50 MHz
  localparam int REFIH = 195;   // 3.9 us at 50 MHz
  localparam int TRP   = 3;
  localparam int TRFC  = 18;
  localparam int MAXP  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hot = 1'b0;
  logic gnt = 1'b0;
  logic [NB-1:0] bopen = '0;
  logic req, urg, pre, rf, stall;

  int cyc = 0;
  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sdram_refresh_sched #(.NUM_BANKS(NB), .REFI_CYC(REFI), .T_RP(TRP),
                        .T_RFC(TRFC), .MAX_PEND(MAXP)) i_sdram_refresh_sched (
    .clk_i(clk), .rst_ni(rst_n), .hot_i(hot), .gnt_i(gnt), .bank_open_i(bopen),
    .req_o(req), .urgent_o(urg), .pre_all_o(pre), .ref_o(rf), .stall_o(stall)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_ref(output int at);
    int k;
    k = 0;
    @(negedge clk);
    while (!rf && k < 2000) begin
      @(negedge clk);
      k++;
    end
    if (!rf) chk("ref timeout", 0, 1);
    at = cyc;
  endtask

  task automatic wait_req();
    int k;
    k = 0;
    @(negedge clk);
    while (!req && k < 2000) begin
      @(negedge clk);
      k++;
    end
    if (!req) chk("req timeout", 0, 1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R9 req at reset", req, 0);
    chk("R9 stall at reset", stall, 0);
    chk("R9 cmds at reset", pre | rf | urg, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_normal_interval();
    int a, b;
    gnt = 1'b1; bopen = '0; hot = 1'b0;
    wait_ref(a);
    wait_ref(b);
    chk("R1 normal interval", b - a, REFI);
    repeat (100) @(negedge clk);
    chk("R7 grant while idle gives no command", pre | rf | req, 0);
  endtask

  task automatic t_hot_switch();
    int a, b, c, d;
    wait_ref(a);
    hot = 1'b1;            // changed inside a running interval
    wait_ref(b);
    chk("R3 running interval keeps old length", b - a, REFI);
    wait_ref(c);
    chk("R3 next interval uses new length", c - b, REFIH);
    wait_ref(d);
    chk("R2 hot interval", d - c, REFIH);
  endtask

  task automatic t_precharge_path();
    int p, r, s;
    gnt = 1'b0; bopen = 8'h05;
    wait_req();
    chk("R7 waiting without stall", stall, 0);
    chk("R7 no command before grant", pre | rf, 0);
    gnt = 1'b1;
    @(negedge clk);
    chk("R4 precharge-all after grant", pre, 1);
    chk("R6 stall from first command", stall, 1);
    p = cyc;
    gnt = 1'b0; bopen = '0;   // late change must be ignored
    wait_ref(r);
    chk("R4 ref spacing after precharge", r - p, TRP);
    s = r;
    while (stall && cyc - r < 100) @(negedge clk);
    s = cyc;
    chk("R6 stall length after ref", s - r, TRFC);
  endtask

  task automatic t_direct_path();
    gnt = 1'b0; bopen = '0;
    wait_req();
    gnt = 1'b1;
    @(negedge clk);
    chk("R5 direct ref after grant", rf, 1);
    chk("R5 no precharge when closed", pre, 0);
    gnt = 1'b0;
  endtask

  task automatic t_backlog();
    int a1, a2;
    gnt = 1'b0; bopen = '0;
    wait_req();
    repeat (6 * REFIH + REFIH / 2) @(negedge clk);
    chk("R8 not urgent at seven owed", urg, 0);
    chk("R7 still requesting", req, 1);
    chk("R7 no stall below limit", stall, 0);
    repeat (REFIH) @(negedge clk);
    chk("R8 urgent at eight owed", urg, 1);
    chk("R8 urgent forces stall", stall, 1);
    repeat (3 * REFIH) @(negedge clk);
    chk("R8 saturated stays urgent", urg, 1);
    gnt = 1'b1;
    wait_ref(a1);
    @(negedge clk);
    chk("R8 urgent drops after one refresh", urg, 0);
    wait_ref(a2);
    chk("R8 back-to-back drain spacing", a2 - a1, TRFC + 2);
  endtask

  task automatic t_mid_reset();
    int a, seen;
    wait_ref(a);
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R9 stall cleared by reset", stall, 0);
    chk("R9 outputs cleared by reset", req | pre | rf | urg, 0);
    @(negedge clk);
    rst_n = 1'b1;
    seen = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      seen = seen | req | rf;
    end
    chk("R9 timer and backlog cleared", seen, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_normal_interval();
    t_hot_switch();
    t_precharge_path();
    t_direct_path();
    t_backlog();
    t_mid_reset();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

endmodule